// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two 8-input priority units into a 15-source interrupt system. One is the primary unit, whose output goes to the CPU. The other is the secondary unit. Its winning request is fed into input 2 of the primary unit as a single edge event. Each unit keeps a request register and an in-service register. A request is captured either on a rising edge or as a live level, chosen per input. Each unit resolves its winner under a rotating priority base. A request wins only if it outranks every input already in service.

When the CPU side raises a one-cycle acknowledge strobe, the block picks the current winner. It marks that input in service and drops the request if the input is edge-captured. On the next clock it presents an 8-bit vector together with a one-cycle done pulse. When the primary winner is the cascade input, the secondary unit is acknowledged in the same cycle and supplies the vector. When no request is left, a spurious vector at index 7 is returned. Each unit can end service automatically at acknowledge time and, if chosen, rotate its priority past the served input.

The vector output is a plain one-cycle valid pulse (`ack_done`). There is no ready signal and no back-pressure: the CPU side must take the vector in the cycle `ack_done` is high. A new strobe may follow in any later cycle. All configuration pins are plain static levels, driven by logic outside this block.

Top module: `cai_cascade`

## Requirements
- R1: An input in edge mode (its bit in the level-mode pin is 0) sets its request bit one clock after its line is seen high when it was low in the previous cycle. The bit then stays set after the line falls, until that input is acknowledged. An input in level mode (bit 1) has a request bit equal to its line as sampled on the previous clock.
- R2: A unit's winner is the pending, unmasked request first met when scanning indices from the priority base upward, modulo 8. It wins only if no in-service input is met at or before it in that same order. `int_req` is high exactly when the primary unit has a winner.
- R3: While the secondary unit has a winner, bit 2 of the primary request register is set on the next clock. It is set as an edge event, so it stays set. The primary line pin 2 and the primary level-mode bit 2 have no effect.
- R4: `ack_done` is high for exactly one cycle: the cycle after a cycle in which `ack` was high. It is low out of reset and at all other times.
- R5: On an acknowledge with a primary winner other than input 2, `vector` = {`base_m`[7:3], winner index}. The winner's in-service bit is set. Its request bit is cleared if it is edge-captured and kept if it is level-captured.
- R6: On an acknowledge where the primary winner is input 2 and the secondary unit has a winner, both units are acknowledged. The primary in-service bit 2 is set, the secondary winner is marked in service, and `vector` = {`base_s`[7:3], secondary index}.
- R7: On an acknowledge with no primary winner, `vector` = {`base_m`[7:3], 3'd7}. No request or in-service bit changes.
- R8: On an acknowledge where the primary winner is input 2 but the secondary unit has no winner, `vector` = {`base_s`[7:3], 3'd7}. The primary unit is still acknowledged for input 2.
- R9: In a unit with automatic end-of-interrupt on, an acknowledge leaves that unit's in-service register unchanged. If rotation is also on, that unit's priority base becomes (index + 1) mod 8. Bases start at 0 after reset.
- R10: A masked input (its bit in the mask pin is 1) never wins, but its request bit is still captured and kept. Clearing the mask bit lets it win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_m | input | 8 | Primary unit request lines (bit 2 unused) |
| irq_s | input | 8 | Secondary unit request lines |
| lvl_m | input | 8 | Primary per-input level mode, 1 = level (bit 2 unused) |
| lvl_s | input | 8 | Secondary per-input level mode |
| imr_m | input | 8 | Primary per-input mask, 1 = masked |
| imr_s | input | 8 | Secondary per-input mask |
| base_m | input | 8 | Primary vector base; bits 2:0 ignored |
| base_s | input | 8 | Secondary vector base; bits 2:0 ignored |
| aeoi_m | input | 1 | Primary automatic end-of-interrupt |
| aeoi_s | input | 1 | Secondary automatic end-of-interrupt |
| rot_m | input | 1 | Primary rotate on automatic end-of-interrupt |
| rot_s | input | 1 | Secondary rotate on automatic end-of-interrupt |
| ack | input | 1 | One-cycle acknowledge strobe |
| int_req | output | 1 | Interrupt request to the CPU |
| ack_done | output | 1 | Vector valid pulse |
| vector | output | 8 | Acknowledge vector |
| irr_m | output | 8 | Primary request register |
| isr_m | output | 8 | Primary in-service register |
| irr_s | output | 8 | Secondary request register |
| isr_s | output | 8 | Secondary in-service register |

## Verification
Directed patterns cover several distinctions. A short pulse and a held line tell edge capture apart from level capture. A lower-priority request behind an in-service input shows that in-service blocking works. A secondary pulse shows the two-clock cascade path and the combined acknowledge. A secondary level request that falls before the acknowledge yields the secondary spurious vector. Two pending inputs under rotation show the base moving past the served input. A masked request shows that masking holds the request but hides it. Random line toggles and acknowledges, under random mask, mode and automatic end-of-interrupt settings, are compared every cycle with a bench model of both units.

// File: rtl/cai_pkg.sv
package cai_pkg;
  localparam int UNIT_LINES  = 8;
  localparam int CASCADE_PIN = 2;
  localparam int VECTOR_W    = 8;
  localparam int NUM_UNITS   = 2;
endpackage

// File: rtl/cai_resolver.sv
module cai_resolver #(
  parameter int LINES = 8
) (
  input  logic [LINES-1:0]         req,
  input  logic [LINES-1:0]         busy,
  input  logic [$clog2(LINES)-1:0] rot_base,
  output logic                     win_v,
  output logic [$clog2(LINES)-1:0] win_idx
);
  localparam int IW = $clog2(LINES);
  localparam int RW = IW + 1;

  logic [RW-1:0] req_rank;
  logic [RW-1:0] busy_rank;
  logic [IW-1:0] pos;

  // Scan from lowest rank last so the best rank is left in place.
  always_comb begin
    req_rank  = RW'(LINES);
    busy_rank = RW'(LINES);
    win_idx   = '0;
    pos       = '0;
    for (int p = LINES - 1; p >= 0; p--) begin
      pos = rot_base + IW'(p);
      if (req[pos]) begin
        req_rank = RW'(p);
        win_idx  = pos;
      end
      if (busy[pos]) busy_rank = RW'(p);
    end
    win_v = (req_rank < busy_rank);
  end
endmodule

// File: rtl/cai_unit.sv
module cai_unit #(
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         line,
  input  logic [LINES-1:0]         lvl,
  input  logic [LINES-1:0]         imr,
  input  logic [LINES-1:0]         cas_set,
  input  logic                     aeoi,
  input  logic                     rot,
  input  logic                     ack,
  input  logic [$clog2(LINES)-1:0] ack_idx,
  output logic [LINES-1:0]         irr,
  output logic [LINES-1:0]         isr,
  output logic                     win_v,
  output logic [$clog2(LINES)-1:0] win_idx
);
  localparam int IW = $clog2(LINES);

  logic [LINES-1:0] last_q;
  logic [IW-1:0]    base_q;
  logic [LINES-1:0] ack_bit;
  logic [LINES-1:0] edge_set;
  logic [LINES-1:0] irr_nxt;
  logic [LINES-1:0] isr_nxt;
  logic [IW-1:0]    base_nxt;

  cai_resolver #(.LINES(LINES)) u_res (
    .req      (irr & ~imr),
    .busy     (isr),
    .rot_base (base_q),
    .win_v    (win_v),
    .win_idx  (win_idx)
  );

  always_comb begin
    ack_bit  = ack ? (LINES'(1) << ack_idx) : '0;
    edge_set = (line & ~last_q) | cas_set;
    // Level inputs follow the line; edge inputs hold until acknowledged.
    irr_nxt  = (lvl & line) | (~lvl & ((irr & ~ack_bit) | edge_set));
    isr_nxt  = aeoi ? isr : (isr | ack_bit);
    base_nxt = (ack && aeoi && rot) ? IW'(ack_idx + 1'b1) : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr    <= '0;
      isr    <= '0;
      last_q <= '0;
      base_q <= '0;
    end else begin
      irr    <= irr_nxt;
      isr    <= isr_nxt;
      last_q <= line;
      base_q <= base_nxt;
    end
  end
endmodule

// File: rtl/cai_cascade.sv
module cai_cascade
  import cai_pkg::*;
#(
  parameter int LINES   = UNIT_LINES,
  parameter int CAS_PIN = CASCADE_PIN,
  parameter int VEC_W   = VECTOR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_m,
  input  logic [LINES-1:0] irq_s,
  input  logic [LINES-1:0] lvl_m,
  input  logic [LINES-1:0] lvl_s,
  input  logic [LINES-1:0] imr_m,
  input  logic [LINES-1:0] imr_s,
  input  logic [VEC_W-1:0] base_m,
  input  logic [VEC_W-1:0] base_s,
  input  logic             aeoi_m,
  input  logic             aeoi_s,
  input  logic             rot_m,
  input  logic             rot_s,
  input  logic             ack,
  output logic             int_req,
  output logic             ack_done,
  output logic [VEC_W-1:0] vector,
  output logic [LINES-1:0] irr_m,
  output logic [LINES-1:0] isr_m,
  output logic [LINES-1:0] irr_s,
  output logic [LINES-1:0] isr_s
);
  localparam int IW     = $clog2(LINES);
  localparam int KEEP_W = VEC_W - IW;
  localparam logic [LINES-1:0] CAS_BIT = LINES'(1) << CAS_PIN;
  localparam logic [IW-1:0]    SPUR    = IW'(LINES - 1);
  localparam logic [IW-1:0]    CAS_IDX = IW'(CAS_PIN);

  logic [LINES-1:0] line_a  [NUM_UNITS];
  logic [LINES-1:0] lvl_a   [NUM_UNITS];
  logic [LINES-1:0] imr_a   [NUM_UNITS];
  logic [LINES-1:0] cas_a   [NUM_UNITS];
  logic [LINES-1:0] irr_a   [NUM_UNITS];
  logic [LINES-1:0] isr_a   [NUM_UNITS];
  logic             aeoi_a  [NUM_UNITS];
  logic             rot_a   [NUM_UNITS];
  logic             ack_a   [NUM_UNITS];
  logic             win_v_a [NUM_UNITS];
  logic [IW-1:0]    win_i_a [NUM_UNITS];

  logic             via_cas;
  logic [VEC_W-1:0] vec_nxt;

  // Primary input CAS_PIN is owned by the cascade path only.
  assign line_a[0] = irq_m & ~CAS_BIT;
  assign lvl_a[0]  = lvl_m & ~CAS_BIT;
  assign imr_a[0]  = imr_m;
  assign aeoi_a[0] = aeoi_m;
  assign rot_a[0]  = rot_m;
  assign line_a[1] = irq_s;
  assign lvl_a[1]  = lvl_s;
  assign imr_a[1]  = imr_s;
  assign aeoi_a[1] = aeoi_s;
  assign rot_a[1]  = rot_s;
  assign cas_a[1]  = '0;

  always_comb begin
    via_cas  = win_v_a[0] && (win_i_a[0] == CAS_IDX);
    ack_a[0] = ack && win_v_a[0];
    ack_a[1] = ack && via_cas && win_v_a[1];
    // A secondary winner that is being served now does not re-arm input 2.
    cas_a[0] = (win_v_a[1] && !ack_a[1]) ? CAS_BIT : '0;
    if (!win_v_a[0])
      vec_nxt = {base_m[VEC_W-1:IW], SPUR};
    else if (via_cas)
      vec_nxt = {base_s[VEC_W-1:IW], win_v_a[1] ? win_i_a[1] : SPUR};
    else
      vec_nxt = {base_m[VEC_W-1:IW], win_i_a[0]};
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    cai_unit #(.LINES(LINES)) u_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .line    (line_a[u]),
      .lvl     (lvl_a[u]),
      .imr     (imr_a[u]),
      .cas_set (cas_a[u]),
      .aeoi    (aeoi_a[u]),
      .rot     (rot_a[u]),
      .ack     (ack_a[u]),
      .ack_idx (win_i_a[u]),
      .irr     (irr_a[u]),
      .isr     (isr_a[u]),
      .win_v   (win_v_a[u]),
      .win_idx (win_i_a[u])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_done <= 1'b0;
      vector   <= '0;
    end else begin
      ack_done <= ack;
      if (ack) vector <= vec_nxt;
    end
  end

  assign int_req = win_v_a[0];
  assign irr_m   = irr_a[0];
  assign isr_m   = isr_a[0];
  assign irr_s   = irr_a[1];
  assign isr_s   = isr_a[1];

  logic unused_keep;
  assign unused_keep = ^{KEEP_W{1'b0}};
endmodule

// File: rtl/cai_cascade_chk.sv
module cai_cascade_chk #(
  parameter int LINES = 8,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             ack_done,
  input logic             int_req,
  input logic [VEC_W-1:0] vector,
  input logic [LINES-1:0] irr_m,
  input logic [LINES-1:0] imr_m,
  input logic [LINES-1:0] isr_m,
  input logic [LINES-1:0] isr_s,
  input logic             aeoi_m,
  input logic             aeoi_s
);
  a_r4_done_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ack_done);

  a_r4_done_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |-> $past(ack));

  a_r7_spurious_index: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_req) |=> (vector[2:0] == 3'd7));

  a_r2_int_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (|(irr_m & ~imr_m)));

  a_r5_isr_gains_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && !aeoi_m) |=>
      (((isr_m & $past(isr_m)) == $past(isr_m)) && (isr_m != $past(isr_m))));

  a_r9_aeoi_isr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi_m && aeoi_s) |=> ($stable(isr_m) && $stable(isr_s)));
endmodule

bind cai_cascade cai_cascade_chk #(.LINES(LINES), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .ack_done (ack_done),
  .int_req  (int_req),
  .vector   (vector),
  .irr_m    (irr_m),
  .imr_m    (imr_m),
  .isr_m    (isr_m),
  .isr_s    (isr_s),
  .aeoi_m   (aeoi_m),
  .aeoi_s   (aeoi_s)
);

// File: tb/cai_cascade_tb.sv
module cai_cascade_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] irq_m = '0, irq_s = '0, lvl_m = '0, lvl_s = '0;
  logic [7:0] imr_m = '0, imr_s = '0;
  logic [7:0] base_m = 8'h4E, base_s = 8'h75;
  logic aeoi_m = 0, aeoi_s = 0, rot_m = 0, rot_s = 0, ack = 0;
  logic int_req, ack_done;
  logic [7:0] vector, irr_m, isr_m, irr_s, isr_s;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state, index 0 = primary, 1 = secondary
  logic [7:0] m_irr [2];
  logic [7:0] m_isr [2];
  logic [7:0] m_last [2];
  logic [2:0] m_base [2];
  logic [7:0] m_vec;
  logic       m_done;

  always #5 clk = ~clk;

  cai_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .irq_m(irq_m), .irq_s(irq_s),
    .lvl_m(lvl_m), .lvl_s(lvl_s), .imr_m(imr_m), .imr_s(imr_s),
    .base_m(base_m), .base_s(base_s), .aeoi_m(aeoi_m), .aeoi_s(aeoi_s),
    .rot_m(rot_m), .rot_s(rot_s), .ack(ack), .int_req(int_req),
    .ack_done(ack_done), .vector(vector), .irr_m(irr_m), .isr_m(isr_m),
    .irr_s(irr_s), .isr_s(isr_s)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Returns {valid, index} of a unit winner from the R2 rule.
  function automatic logic [3:0] fwin(input logic [7:0] req, input logic [7:0] busy,
                                      input logic [2:0] b);
    int rr = 8, br = 8;
    logic [2:0] wi = '0;
    for (int p = 0; p < 8; p++) begin
      logic [2:0] pos = b + 3'(p);
      if (req[pos] && rr == 8) begin rr = p; wi = pos; end
      if (busy[pos] && br == 8) br = p;
    end
    return {(rr < br), wi};
  endfunction

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      m_irr[u] = '0; m_isr[u] = '0; m_last[u] = '0; m_base[u] = '0;
    end
    m_vec = '0; m_done = 1'b0;
  endtask

  task automatic model_tick();
    logic [3:0] mw, sw;
    logic [7:0] ln [2];
    logic [7:0] lv [2];
    logic [7:0] ab [2];
    logic [2:0] ix [2];
    logic ae [2];
    logic ro [2];
    logic [7:0] cs, es, vec;
    mw = fwin(m_irr[0] & ~imr_m, m_isr[0], m_base[0]);
    sw = fwin(m_irr[1] & ~imr_s, m_isr[1], m_base[1]);
    ab[0] = '0; ab[1] = '0; vec = m_vec;
    ix[0] = mw[2:0]; ix[1] = sw[2:0];
    if (ack) begin
      if (!mw[3]) vec = {base_m[7:3], 3'd7};
      else begin
        ab[0] = 8'd1 << mw[2:0];
        if (mw[2:0] == 3'd2) begin
          if (sw[3]) begin ab[1] = 8'd1 << sw[2:0]; vec = {base_s[7:3], sw[2:0]}; end
          else vec = {base_s[7:3], 3'd7};
        end else vec = {base_m[7:3], mw[2:0]};
      end
    end
    ln[0] = irq_m & 8'hFB; lv[0] = lvl_m & 8'hFB; ln[1] = irq_s; lv[1] = lvl_s;
    ae[0] = aeoi_m; ae[1] = aeoi_s; ro[0] = rot_m; ro[1] = rot_s;
    cs = (sw[3] && ab[1] == 0) ? 8'h04 : 8'h00;
    for (int u = 0; u < 2; u++) begin
      es = (ln[u] & ~m_last[u]) | ((u == 0) ? cs : 8'h00);
      m_irr[u] = (lv[u] & ln[u]) | (~lv[u] & ((m_irr[u] & ~ab[u]) | es));
      if (!ae[u]) m_isr[u] = m_isr[u] | ab[u];
      if (ae[u] && ro[u] && ab[u] != 0) m_base[u] = ix[u] + 3'd1;
      m_last[u] = ln[u];
    end
    m_done = ack;
    m_vec = vec;
  endtask

  task automatic compare();
    logic [3:0] mw;
    mw = fwin(m_irr[0] & ~imr_m, m_isr[0], m_base[0]);
    chk(irr_m == m_irr[0], "R1", "irr_m", irr_m, m_irr[0]);
    chk(irr_s == m_irr[1], "R1", "irr_s", irr_s, m_irr[1]);
    chk(isr_m == m_isr[0], "R5", "isr_m", isr_m, m_isr[0]);
    chk(isr_s == m_isr[1], "R6", "isr_s", isr_s, m_isr[1]);
    chk(int_req == mw[3], "R2", "int_req", int_req, mw[3]);
    chk(ack_done == m_done, "R4", "ack_done", ack_done, m_done);
    if (m_done) chk(vector == m_vec, "R5", "vector", vector, m_vec);
  endtask

  // One clock: model advances on the inputs now applied, then compare.
  task automatic step();
    model_tick();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ack = 1'b0; irq_m = '0; irq_s = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    do_reset();
    // Reset state
    chk(irr_m == 0 && isr_m == 0 && irr_s == 0 && isr_s == 0, "R1", "reset regs", {irr_m, isr_m}, 0);
    chk(int_req == 0, "R2", "reset int_req", int_req, 0);
    chk(ack_done == 0, "R4", "reset done", ack_done, 0);

    // Edge capture; primary pin 2 and its level bit are ignored (R3)
    irq_m = 8'h24; lvl_m = 8'h04; step();
    irq_m = 8'h00; step();
    lvl_m = 8'h00;
    chk(irr_m == 8'h20, "R1", "edge held, pin2 ignored", irr_m, 8'h20);
    chk(irr_m[2] == 1'b0, "R3", "primary pin2 no effect", irr_m, 8'h20);
    chk(int_req == 1'b1, "R2", "int_req with pending", int_req, 1);

    pulse_ack();
    chk(ack_done == 1'b1, "R4", "done after ack", ack_done, 1);
    chk(vector == 8'h4D, "R5", "primary vector", vector, 8'h4D);
    chk(isr_m == 8'h20 && irr_m == 8'h00, "R5", "edge ack state", {isr_m, irr_m}, 16'h2000);
    step();
    chk(ack_done == 1'b0, "R4", "done one cycle", ack_done, 0);

    // Lower priority behind in-service input 5 is blocked
    irq_m = 8'h40; step(); irq_m = 8'h00; step();
    chk(irr_m == 8'h40 && int_req == 1'b0, "R2", "blocked by in-service", {irr_m, 7'd0, int_req}, 16'h4000);

    pulse_ack();
    chk(vector == 8'h4F, "R7", "primary spurious", vector, 8'h4F);
    chk(isr_m == 8'h20 && irr_m == 8'h40, "R7", "spurious no change", {isr_m, irr_m}, 16'h2040);

    // Level capture
    do_reset();
    lvl_m = 8'h10; irq_m = 8'h10; step();
    chk(irr_m == 8'h10, "R1", "level captured", irr_m, 8'h10);
    pulse_ack();
    chk(vector == 8'h4C && isr_m == 8'h10 && irr_m == 8'h10, "R5", "level kept",
        {vector, isr_m, irr_m}, 24'h4C1010);
    irq_m = 8'h00; step();
    chk(irr_m == 8'h00, "R1", "level follows line", irr_m, 0);
    lvl_m = 8'h00;

    // Cascade path
    do_reset();
    irq_s = 8'h08; step(); irq_s = 8'h00;
    chk(irr_s == 8'h08 && irr_m == 8'h00, "R3", "cascade not yet", {irr_s, irr_m}, 16'h0800);
    step();
    chk(irr_m == 8'h04 && int_req == 1'b1, "R3", "cascade sets input 2", irr_m, 8'h04);
    pulse_ack();
    chk(vector == 8'h73, "R6", "secondary vector", vector, 8'h73);
    chk(isr_m == 8'h04 && isr_s == 8'h08 && irr_s == 0 && irr_m == 0, "R6", "both acknowledged",
        {isr_m, isr_s, irr_m, irr_s}, 32'h04080000);

    // Secondary spurious
    do_reset();
    lvl_s = 8'h02; irq_s = 8'h02; step(); step(); irq_s = 8'h00; step();
    chk(irr_s == 8'h00 && irr_m == 8'h04, "R8", "request gone", {irr_s, irr_m}, 16'h0004);
    pulse_ack();
    chk(vector == 8'h77 && isr_m == 8'h04 && isr_s == 0, "R8", "secondary spurious",
        {vector, isr_m, isr_s}, 24'h770400);
    lvl_s = 8'h00;

    // Automatic end-of-interrupt with rotation
    do_reset();
    aeoi_m = 1; rot_m = 1;
    irq_m = 8'h42; step(); irq_m = 8'h00; step();
    pulse_ack();
    chk(vector == 8'h49 && isr_m == 8'h00, "R9", "aeoi no in-service", {vector, isr_m}, 16'h4900);
    irq_m = 8'h01; step(); irq_m = 8'h00; step();
    pulse_ack();
    chk(vector == 8'h4E, "R9", "rotated priority", vector, 8'h4E);
    aeoi_m = 0; rot_m = 0;

    // Masking
    do_reset();
    imr_m = 8'h08; irq_m = 8'h08; step(); irq_m = 8'h00; step();
    chk(irr_m == 8'h08 && int_req == 1'b0, "R10", "masked held", {irr_m, 7'd0, int_req}, 16'h0800);
    pulse_ack();
    chk(vector == 8'h4F && irr_m == 8'h08, "R10", "masked not served", {vector, irr_m}, 16'h4F08);
    imr_m = 8'h00; step();
    chk(int_req == 1'b1, "R10", "unmasked wins", int_req, 1);

    // Random phases checked every cycle against the model
    for (int ph = 0; ph < 6; ph++) begin
      do_reset();
      aeoi_m = 1'($urandom); aeoi_s = 1'($urandom);
      rot_m = 1'($urandom); rot_s = 1'($urandom);
      lvl_m = 8'($urandom) & 8'($urandom); lvl_s = 8'($urandom) & 8'($urandom);
      imr_m = 8'($urandom) & 8'($urandom) & 8'($urandom);
      imr_s = 8'($urandom) & 8'($urandom) & 8'($urandom);
      base_m = 8'($urandom); base_s = 8'($urandom);
      for (int c = 0; c < 400; c++) begin
        irq_m = irq_m ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
        irq_s = irq_s ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
        ack = ($urandom % 5) == 0;
        step();
      end
      ack = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule